// File: doc/BRIEF.md
# Qualified Bit-Error Accumulator

This block sits behind a receiver's data slicer and a second, offset slicer. Every clock it takes one received word and one offset-sample word of the same width, forms a mismatch word, and keeps the last two cycles of both in a shift history. The history is twice the word width. The upper half holds the previous cycle and the lower half holds the current cycle. A masked pattern match over the data history decides whether the cycle qualifies. Qualified cycles advance a power-of-two prescaler that feeds a sample counter. The same cycles add errors to an error counter.

Two error-counting modes are chosen from the shape of the error mask. In the bit-accumulating mode, used for a statistical eye, the counter adds the number of unmasked mismatch bits in the current word. In the event mode, used for waveform or scope views, it adds at most one per cycle. Both counters freeze as soon as either one is full. The counters stay frozen until a synchronous clear starts a new accumulation.

Top module: `qual_err_accum`

## Requirements
- R1: The history shifts once per clock. Bits [W-1:0] hold the word presented in the latest cycle and bits [2W-1:W] hold the word presented one cycle earlier, for both data and mismatch. A cycle is counted from the history as it stands before the edge that counts it.
- R2: With `det_en` high, a mismatch bit is the XOR of the data bit and the offset bit. With `det_en` low, it is the raw offset bit.
- R3: A cycle qualifies only when every history bit k equals `qual_pat[k]` or has `qual_mask[k]` = 1. When a cycle does not qualify, neither counter changes.
- R4: The sample counter rises by one per 2^(P+1) qualified, enabled cycles, where P is `prescale`.
- R5: When `err_mask[2W-1:W]` is all ones and more than one mask bit is 0, a qualified cycle adds the count of k in [W-1:0] where the mismatch bit is 1 and `err_mask[k]` is 0.
- R6: When exactly one bit of `err_mask` is 0, or any bit of `err_mask[2W-1:W]` is 0, a qualified cycle adds 1 if any unmasked mismatch bit in the whole history is 1, and adds 0 otherwise.
- R7: `saturated` is high while either counter is at its all-ones value. While it is high, neither counter changes until a clear.
- R8: After reset, and in the cycle after `clear` is high, both counters, the prescaler and `saturated` are zero.
- R9: A bit-count addition that would pass the maximum leaves the error counter at all ones, and `saturated` rises on the same edge.
- R10: While `enable` is low, neither the counters nor the prescaler phase advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of counters and prescaler |
| enable | input | 1 | Allows accumulation |
| det_en | input | 1 | 1: mismatch = data XOR offset; 0: mismatch = offset |
| rx_word | input | W | Received data word |
| off_word | input | W | Offset-sample word |
| qual_pat | input | 2W | Qualifier pattern over the data history |
| qual_mask | input | 2W | 1 = history bit excluded from qualification |
| err_mask | input | 2W | 1 = mismatch bit excluded from error counting |
| prescale | input | PSW | Prescale exponent P (ratio 2^(P+1)) |
| sample_cnt | output | CW | Prescaled qualified-sample count |
| error_cnt | output | CW | Error count |
| saturated | output | 1 | Either counter at its maximum |

## Verification
The bench builds the block with a 16-bit word, a 6-bit counter and a 2-bit prescale exponent. The 6-bit counter fills within a few dozen to about 130 cycles, so freezing on a full error counter, freezing on a full sample counter, and the clamp from 60 by a step of 8 can all be reached directly. The 32-bit history is short enough to hand-write patterns that tell the previous word apart from the current one. Those patterns also separate the event mode from the bit-accumulating mode, and a single mask bit in either half is enough to switch between them.

// File: rtl/qual_err_accum.sv
module qual_err_accum #(
  parameter int W   = 80,
  parameter int CW  = 16,
  parameter int PSW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             det_en,
  input  logic [W-1:0]     rx_word,
  input  logic [W-1:0]     off_word,
  input  logic [2*W-1:0]   qual_pat,
  input  logic [2*W-1:0]   qual_mask,
  input  logic [2*W-1:0]   err_mask,
  input  logic [PSW-1:0]   prescale,
  output logic [CW-1:0]    sample_cnt,
  output logic [CW-1:0]    error_cnt,
  output logic             saturated
);
  localparam int HW    = 2 * W;
  localparam int PCW   = (2 ** PSW) + 1;
  localparam int PCNTW = $clog2(W + 1);
  localparam int SW    = CW + PCNTW;
  localparam logic [CW-1:0] CMAX    = '1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [HW-1:0]  dhist, mhist;
  logic [PCW-1:0] pcnt;

  wire [W-1:0]  mism_now = det_en ? (rx_word ^ off_word) : off_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dhist <= '0;
      mhist <= '0;
    end else begin
      dhist <= {dhist[W-1:0], rx_word};
      mhist <= {mhist[W-1:0], mism_now};
    end

  wire qual_hit = &((dhist ~^ qual_pat) | qual_mask);

  wire [HW-1:0] err_vec     = mhist & ~err_mask;
  wire [HW-1:0] open_bits   = ~err_mask;
  wire          single_open = (open_bits != '0) && ((open_bits & (open_bits - HW'(1))) == '0);
  wire          upper_open  = ~&err_mask[HW-1:W];
  wire          ev_mode     = upper_open | single_open;

  function automatic logic [PCNTW-1:0] popc(input logic [W-1:0] v);
    logic [PCNTW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) r += {{(PCNTW-1){1'b0}}, v[i]};
    return r;
  endfunction

  wire [SW-1:0] err_add = ev_mode ? SW'(|err_vec) : SW'(popc(err_vec[W-1:0]));
  wire [SW-1:0] err_sum = SW'(error_cnt) + err_add;
  wire [CW-1:0] err_nxt = (err_sum > SW'(CMAX)) ? CMAX : err_sum[CW-1:0];

  wire [PCW-1:0] pre_lim  = (PCW'(1) << ({1'b0, prescale} + 1'b1)) - PCW'(1);
  wire           pre_wrap = (pcnt == pre_lim);

  assign saturated = (sample_cnt == CMAX) | (error_cnt == CMAX);
  wire active = enable & qual_hit & ~saturated;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pcnt       <= '0;
      sample_cnt <= '0;
      error_cnt  <= '0;
    end else if (clear) begin
      pcnt       <= '0;
      sample_cnt <= '0;
      error_cnt  <= '0;
    end else if (active) begin
      pcnt      <= pre_wrap ? '0 : pcnt + PCW'(1);
      error_cnt <= err_nxt;
      if (pre_wrap) sample_cnt <= sample_cnt + CNT_ONE;
    end

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sample_cnt == '0) && (error_cnt == '0) && !saturated);

  assert_frozen_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    saturated && !clear |=> $stable(sample_cnt) && $stable(error_cnt));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !clear |=> $stable(sample_cnt) && $stable(error_cnt));

  assert_unqualified_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_hit && !clear |=> $stable(sample_cnt) && $stable(error_cnt));

  assert_sample_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (sample_cnt == $past(sample_cnt)) || (sample_cnt == $past(sample_cnt) + CNT_ONE));

  assert_event_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mode && !clear |=> (error_cnt == $past(error_cnt)) || (error_cnt == $past(error_cnt) + CNT_ONE));

  assert_err_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> error_cnt >= $past(error_cnt));
endmodule

// File: tb/tb_qual_err_accum.sv
module tb_qual_err_accum;
  localparam int W = 16, CW = 6, PSW = 2, HW = 2 * W;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, clear = 0, enable = 0, det_en = 0;
  logic [W-1:0] rx_word = '0, off_word = '0;
  logic [HW-1:0] qual_pat = '0, qual_mask = '1, err_mask = '1;
  logic [PSW-1:0] prescale = '0;
  logic [CW-1:0] sample_cnt, error_cnt;
  logic saturated;
  int tests = 0, fails = 0;

  qual_err_accum #(.W(W), .CW(CW), .PSW(PSW)) dut (.*);

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] d, input logic [W-1:0] o);
    @(negedge clk); rx_word = d; off_word = o;
    @(posedge clk);
  endtask

  task automatic run(input int n);
    @(negedge clk); enable = 1;
    repeat (n) @(negedge clk);
    enable = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  task automatic t_reset();
    chk("R8 reset sample", sample_cnt, 0);
    chk("R8 reset error", error_cnt, 0);
    chk("R8 reset sat", saturated, 0);
  endtask

  task automatic t_popcount();
    do_clear(); det_en = 1; qual_mask = '1; err_mask = {16'hFFFF, 16'h0000};
    push(16'h00FF, 16'h0F0F); push(16'h00FF, 16'h0F0F);
    run(1);
    chk("R5 popcount all open", error_cnt, 8);
    do_clear(); err_mask = {16'hFFFF, 16'h00F0};
    run(1);
    chk("R5 popcount partly masked", error_cnt, 4);
  endtask

  task automatic t_detect();
    do_clear(); err_mask = {16'hFFFF, 16'h0000}; det_en = 0;
    push(16'hFFFF, 16'h0007); push(16'hFFFF, 16'h0007);
    run(1);
    chk("R2 raw offset bits", error_cnt, 3);
    do_clear(); det_en = 1;
    push(16'hFFFF, 16'h0007); push(16'hFFFF, 16'h0007);
    run(1);
    chk("R2 xor mismatch", error_cnt, 13);
  endtask

  task automatic t_event();
    do_clear(); det_en = 0; err_mask = {16'hFFFB, 16'hFFFF};
    push(16'h0, 16'h0004); push(16'h0, 16'hFFFF);
    run(1);
    chk("R1 R6 previous word bit counted once", error_cnt, 1);
    do_clear(); err_mask = {16'hFFFE, 16'h0000};
    push(16'h0, 16'h0001); push(16'h0, 16'hFFFF);
    run(1);
    chk("R6 upper open gives single step", error_cnt, 1);
    do_clear(); err_mask = {16'hFFFF, 16'hFFDF};
    push(16'h0, 16'h0); push(16'h0, 16'h0020);
    run(1);
    chk("R6 single lower bit set", error_cnt, 1);
    push(16'h0, 16'h0); push(16'h0, 16'hFFDF);
    run(1);
    chk("R6 single lower bit clear", error_cnt, 1);
  endtask

  task automatic t_qualify();
    do_clear(); det_en = 0; prescale = 0; err_mask = {16'hFFFF, 16'h0000};
    qual_pat = {16'h1234, 16'hABCD}; qual_mask = '0;
    push(16'h1234, 16'h1); push(16'hABCD, 16'h1);
    run(1);
    chk("R1 R3 exact history match", error_cnt, 1);
    qual_pat = {16'hABCD, 16'h1234};
    push(16'h1234, 16'h1); push(16'hABCD, 16'h1);
    run(1);
    chk("R3 swapped words rejected", error_cnt, 1);
    qual_pat = {16'h1234, 16'hABCC}; qual_mask = {16'h0000, 16'h0001};
    push(16'h1234, 16'h1); push(16'hABCD, 16'h1);
    run(1);
    chk("R3 masked bit ignored", error_cnt, 2);
    chk("R4 two qualified cycles one sample", sample_cnt, 1);
    qual_mask = '1;
  endtask

  task automatic t_prescale();
    do_clear(); err_mask = '1; prescale = 2;
    run(7);
    chk("R4 seven of eight", sample_cnt, 0);
    run(1);
    chk("R4 eighth cycle", sample_cnt, 1);
    run(8);
    chk("R4 sixteen cycles", sample_cnt, 2);
    chk("R5 fully masked adds nothing", error_cnt, 0);
  endtask

  task automatic t_enable();
    do_clear(); prescale = 0;
    run(1);
    repeat (6) @(negedge clk);
    chk("R10 idle holds sample", sample_cnt, 0);
    run(1);
    chk("R10 prescaler phase kept", sample_cnt, 1);
  endtask

  task automatic t_saturate();
    do_clear(); det_en = 0; prescale = 0; err_mask = {16'hFFFF, 16'h0000};
    push(16'h0, 16'h0001); push(16'h0, 16'h0001);
    run(100);
    chk("R7 error full", error_cnt, 63);
    chk("R7 sample frozen", sample_cnt, 31);
    chk("R7 sat flag", saturated, 1);
    do_clear();
    chk("R8 clear sample", sample_cnt, 0);
    chk("R8 clear error", error_cnt, 0);
    chk("R8 clear sat", saturated, 0);
    err_mask = '1;
    run(140);
    chk("R7 sample full", sample_cnt, 63);
    chk("R7 error frozen", error_cnt, 0);
  endtask

  task automatic t_clamp();
    do_clear(); det_en = 0; prescale = 0; err_mask = {16'hFFFF, 16'h0000};
    push(16'h0, 16'h000F); push(16'h0, 16'h000F);
    run(15);
    chk("R9 pre clamp", error_cnt, 60);
    chk("R9 not yet sat", saturated, 0);
    push(16'h0, 16'h00FF); push(16'h0, 16'h00FF);
    run(1);
    chk("R9 clamped", error_cnt, 63);
    chk("R9 sat same edge", saturated, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_popcount();
    t_detect();
    t_event();
    t_qualify();
    t_prescale();
    t_enable();
    t_saturate();
    t_clamp();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule